// File: doc/BRIEF.md
# Handshaked Control Bus Register Target

This block is the peripheral end of a narrow control bus. A bus master selects it by pulling an active-low select line, and presents an address, a read/write flag and (on writes) a data byte. The block holds a small bank of byte-wide registers: a fixed identity byte, an event register, an interrupt mask and a general control byte whose value is exported to the surrounding logic. Every transfer is closed by an acknowledge that the block pulls low and later releases, so the master paces each access by the handshake rather than by a fixed latency.

External event inputs set sticky bits in the event register. Software clears them by writing ones. While any set event bit is also enabled in the mask, the block pulls the shared interrupt line. Both the acknowledge and interrupt lines are open-drain. The block therefore exposes a pull-low enable for each line, and several targets can share one wire. The bus parity bit is disabled in this configuration and has no effect.

Top module: `cbus_reg_target`

## Requirements
- R1: During and after reset, ack_pull_o, irq_pull_o and data_oe_o are 0, ctrl_o is 0x00, and the mask and event registers are 0x00.
- R2: With ACK_DLY = N (default 2, N >= 1), ack_pull_o goes to 1 after the Nth clock edge that follows the first rising edge at which cs_ni is sampled low. It stays 1 while cs_ni remains low.
- R3: ack_pull_o returns to 0 after the first rising edge at which cs_ni is sampled high. A cycle whose select is withdrawn before acknowledge performs no write.
- R4: data_oe_o is 1 exactly while cs_ni is low and rw_i is 1 (read). While data_oe_o is 1, data_o carries the contents of the addressed register.
- R5: A write (rw_i = 0) to address 0x02 loads the mask, and a write to 0x03 loads ctrl_o. The write takes effect once per cycle, at the edge where acknowledge is asserted. Both registers read back at their addresses.
- R6: Address 0x00 reads the ID_VALUE parameter (default 0xA5). Writes to it are acknowledged and ignored.
- R7: An event bit at address 0x01 is set at any edge where the matching evt_i bit is 1, and it stays set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R8: irq_pull_o is 1 exactly while the bitwise AND of the event register and the mask is non-zero.
- R9: Reads of any address other than 0x00 to 0x03 return 0x00 and are acknowledged. Writes to such addresses are acknowledged and change no register.
- R10: The parity input par_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low select; low starts a transfer |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | AW | Register address |
| data_i | input | DW | Write data from the bus |
| data_o | output | DW | Read data to the bus |
| data_oe_o | output | 1 | Data bus drive enable |
| par_i | input | 1 | Bus parity bit, ignored |
| evt_i | input | DW | Event set inputs, one per event bit |
| ctrl_o | output | DW | Control register contents |
| ack_pull_o | output | 1 | 1 pulls the shared acknowledge line low |
| irq_pull_o | output | 1 | 1 pulls the shared interrupt line low |

## Verification
A handshake counter that is off by one moves the acknowledge edge. That error shows at ack_pull_o on the first transfer, within ACK_DLY+1 cycles of select falling. A write strobe that fires twice, or fires on an aborted cycle, leaves a wrong mask or control value. The control value is visible on ctrl_o immediately, and a wrong mask shows on irq_pull_o or on the next read. A wrong event set/clear priority shows as a wrong interrupt level in the same cycle and as a wrong byte on the next event read. The bench compares all these outputs against a behavioural model on every cycle, so a divergence is reported in the cycle where it first appears.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;

  localparam int unsigned REG_ID   = 0;
  localparam int unsigned REG_EVT  = 1;
  localparam int unsigned REG_MASK = 2;
  localparam int unsigned REG_CTRL = 3;
endpackage

// File: rtl/cbus_handshake.sv
module cbus_handshake
  import cbus_pkg::*;
#(
  parameter int unsigned ACK_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rw_i,
  output logic ack_o,
  output logic wr_stb_o
);
  localparam int unsigned CW = $clog2(ACK_DLY + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_DLY);

  hs_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_wait;

  assign last_wait = (state_q == HS_WAIT) && !cs_ni && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      HS_IDLE: if (!cs_ni) begin
        state_d = HS_WAIT;
        cnt_d   = CW'(1);
      end
      HS_WAIT: begin
        if (cs_ni)          state_d = HS_IDLE;
        else if (last_wait) state_d = HS_ACK;
        else                cnt_d   = cnt_q + CW'(1);
      end
      HS_ACK:  if (cs_ni) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ack_o    = (state_q == HS_ACK);
  assign wr_stb_o = last_wait && !rw_i;

  // select-low run length, used only by the checks below
  logic [7:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             low_run_q <= '0;
    else if (cs_ni)          low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 8'd1;
  end

  a_r2_ack_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> (32'(low_run_q) == ACK_DLY + 1));

  a_r3_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !ack_o);

  a_r5_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  a_r2_ack_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(!cs_ni));
endmodule

// File: rtl/cbus_regfile.sv
module cbus_regfile
  import cbus_pkg::*;
#(
  parameter int unsigned      AW       = 8,
  parameter int unsigned      DW       = 8,
  parameter logic [DW-1:0]    ID_VALUE = 8'hA5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] evt_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] ctrl_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_ID   = AW'(REG_ID);
  localparam logic [AW-1:0] A_EVT  = AW'(REG_EVT);
  localparam logic [AW-1:0] A_MASK = AW'(REG_MASK);
  localparam logic [AW-1:0] A_CTRL = AW'(REG_CTRL);

  logic [DW-1:0] evt_q, mask_q, ctrl_q, clr_bits;

  assign clr_bits = (wr_stb_i && addr_i == A_EVT) ? wdata_i : '0;

  // per-bit sticky events; set has priority over write-one-clear
  for (genvar b = 0; b < DW; b++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       evt_q[b] <= 1'b0;
      else if (evt_i[b]) evt_q[b] <= 1'b1;
      else if (clr_bits[b]) evt_q[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (wr_stb_i) begin
      if (addr_i == A_MASK) mask_q <= wdata_i;
      if (addr_i == A_CTRL) ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_ID:    rdata_o = ID_VALUE;
      A_EVT:   rdata_o = evt_q;
      A_MASK:  rdata_o = mask_q;
      A_CTRL:  rdata_o = ctrl_q;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = |(evt_q & mask_q);

  a_r7_evt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((evt_q & $past(evt_i)) == $past(evt_i)));

  a_r7_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  a_r5_mask_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> ($stable(mask_q) && $stable(ctrl_q)));

  a_r8_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|evt_i) || $past(wr_stb_i)));
endmodule

// File: rtl/cbus_reg_target.sv
module cbus_reg_target
  import cbus_pkg::*;
#(
  parameter int unsigned   AW       = 8,
  parameter int unsigned   DW       = 8,
  parameter int unsigned   ACK_DLY  = 2,
  parameter logic [DW-1:0] ID_VALUE = 8'hA5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic          par_i,
  input  logic [DW-1:0] evt_i,
  output logic [DW-1:0] ctrl_o,
  output logic          ack_pull_o,
  output logic          irq_pull_o
);
  logic wr_stb;
  logic unused_par;

  assign unused_par = par_i;  // parity disabled

  cbus_handshake #(.ACK_DLY(ACK_DLY)) u_hs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .rw_i     (rw_i),
    .ack_o    (ack_pull_o),
    .wr_stb_o (wr_stb)
  );

  cbus_regfile #(.AW(AW), .DW(DW), .ID_VALUE(ID_VALUE)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wr_stb),
    .addr_i   (addr_i),
    .wdata_i  (data_i),
    .evt_i    (evt_i),
    .rdata_o  (data_o),
    .ctrl_o   (ctrl_o),
    .irq_o    (irq_pull_o)
  );

  assign data_oe_o = !cs_ni && rw_i;

  a_r4_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb) |-> !data_oe_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> (!ack_pull_o && !data_oe_o));
endmodule

// File: tb/tb_cbus_reg_target.sv
module tb_cbus_reg_target;
  localparam int unsigned ACK_DLY = 2;
  localparam logic [7:0]  ID_VAL  = 8'hA5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rw = 1'b1;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       par = 1'b0;
  logic [7:0] evt = '0;
  logic [7:0] evt_force = '0;
  bit         evt_rand = 1'b0;
  logic [7:0] rdata, ctrl;
  logic       oe, ack, irq;

  int vectors = 0;
  int miscompares = 0;
  string phase = "reset";

  always #5 clk = ~clk;

  cbus_reg_target #(.ACK_DLY(ACK_DLY), .ID_VALUE(ID_VAL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rw_i(rw), .addr_i(addr),
    .data_i(wdata), .data_o(rdata), .data_oe_o(oe), .par_i(par),
    .evt_i(evt), .ctrl_o(ctrl), .ack_pull_o(ack), .irq_pull_o(irq)
  );

  // behavioural reference
  int         low_run;
  logic       m_ack;
  logic [7:0] m_evt, m_mask, m_ctrl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run = 0; m_ack = 0; m_evt = 0; m_mask = 0; m_ctrl = 0;
    end else begin
      logic do_wr;
      if (cs_n) low_run = 0;
      else if (low_run < 1000) low_run++;
      do_wr = !cs_n && !rw && (low_run == ACK_DLY + 1);
      m_ack = !cs_n && (low_run >= ACK_DLY + 1);
      for (int b = 0; b < 8; b++) begin
        if (evt[b]) m_evt[b] = 1'b1;
        else if (do_wr && addr == 8'h01 && wdata[b]) m_evt[b] = 1'b0;
      end
      if (do_wr && addr == 8'h02) m_mask = wdata;
      if (do_wr && addr == 8'h03) m_ctrl = wdata;
    end
  end

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h00:   return ID_VAL;
      8'h01:   return m_evt;
      8'h02:   return m_mask;
      8'h03:   return m_ctrl;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h00:   return "R6";
      8'h01:   return "R7";
      8'h02, 8'h03: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s [%s] t=%0t act=%02h exp=%02h", tag, phase, $time, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 R3 ack", {7'd0, ack}, {7'd0, m_ack});
      chk("R4 oe", {7'd0, oe}, {7'd0, (!cs_n && rw)});
      chk("R8 irq", {7'd0, irq}, {7'd0, |(m_evt & m_mask)});
      chk("R5 ctrl", ctrl, m_ctrl);
      if (!cs_n && rw) chk(rd_tag(addr), rdata, m_read(addr));
    end
  end

  // event stimulus process
  initial begin
    forever begin
      @(posedge clk); #2;
      evt = evt_force | ((evt_rand && ($urandom % 4 == 0)) ? 8'($urandom) : 8'h00);
    end
  end

  task automatic drive_cycle(input logic r, input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    cs_n = 1'b0; rw = r; addr = a; wdata = d; par = 1'($urandom);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ack) break;
    end
    @(posedge clk); #2;
    cs_n = 1'b1; rw = 1'b1; par = 1'($urandom);
    @(posedge clk); #2;
  endtask

  task automatic abort_cycle(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    cs_n = 1'b0; rw = 1'b0; addr = a; wdata = d;
    @(posedge clk); #2;
    cs_n = 1'b1; rw = 1'b1;
    @(posedge clk); #2;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset values while reset still held
    chk("R1 ack", {7'd0, ack}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 oe", {7'd0, oe}, 8'h00);
    chk("R1 ctrl", ctrl, 8'h00);
    rst_n = 1'b1;

    phase = "R5 ctrl/mask write";
    drive_cycle(1'b0, 8'h03, 8'h5A);
    drive_cycle(1'b1, 8'h03, 8'h00);
    drive_cycle(1'b0, 8'h02, 8'h0F);
    drive_cycle(1'b1, 8'h02, 8'h00);

    phase = "R6 id";
    drive_cycle(1'b1, 8'h00, 8'h00);
    drive_cycle(1'b0, 8'h00, 8'hFF);
    drive_cycle(1'b1, 8'h00, 8'h00);

    phase = "R7 R8 events";
    @(posedge clk); #2; evt_force = 8'h11;
    @(posedge clk); #2; evt_force = 8'h00;
    drive_cycle(1'b1, 8'h01, 8'h00);
    drive_cycle(1'b0, 8'h01, 8'h01);
    drive_cycle(1'b1, 8'h01, 8'h00);
    evt_force = 8'h10;
    drive_cycle(1'b0, 8'h01, 8'h10);  // set wins over clear
    evt_force = 8'h00;
    drive_cycle(1'b1, 8'h01, 8'h00);
    drive_cycle(1'b0, 8'h01, 8'hFF);
    drive_cycle(1'b1, 8'h01, 8'h00);

    phase = "R3 abort";
    abort_cycle(8'h03, 8'h33);
    drive_cycle(1'b1, 8'h03, 8'h00);

    phase = "R9 unmapped";
    drive_cycle(1'b1, 8'h40, 8'h00);
    drive_cycle(1'b1, 8'hFF, 8'h00);
    drive_cycle(1'b0, 8'h04, 8'hEE);
    drive_cycle(1'b1, 8'h03, 8'h00);

    phase = "R10 random with parity";
    evt_rand = 1'b1;
    for (int n = 0; n < 60; n++) begin
      logic [7:0] a;
      a = ($urandom % 6 == 5) ? 8'h80 : 8'($urandom % 5);
      drive_cycle(1'($urandom), a, 8'($urandom));
    end
    evt_rand = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule